// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Multiprocessor Flag

This block is a full-duplex asynchronous serial link. Bytes come in on a valid/ready stream and leave as serial characters on `txd`. Characters that arrive on `rxd` come out as bytes on a second valid/ready stream. The character format is set by plain configuration pins:

- 7 or 8 data bits, sent least significant bit first.
- An optional extra bit after the data. It is either an even/odd parity bit or a multiprocessor flag that the sender supplies.
- 1 or 2 stop bits.

Both directions run on a 16x oversample tick. The tick comes either from a fixed internal divider of the core clock or from rising edges of an external 16x clock input, which is synchronised to the core clock. On the internal source, a square wave at the bit rate is driven out for external devices.

The receiver checks the start bit again at its middle and samples every later bit at its middle. It raises sticky framing, parity, overrun and break flags, which stay set until `sts_clr` is pulsed. A set that falls in the same cycle as `sts_clr` wins.

The receive stream applies back-pressure as follows. `rx_valid` and `rx_data` hold until `rx_ready` is seen high. A character that completes while the held byte is still unread is dropped and flags an overrun. The transmit stream accepts a byte when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` is high while the line is idle, and for the single cycle that ends the last stop bit. That cycle lets the next byte follow with no idle gap.

Top module: `uart_mp_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and all four status flags are 0; while the transmitter is idle `txd` stays 1.
- R2: A transmitted character contains the following bits in order, each lasting 16 oversample ticks:
  - a start bit of 0;
  - the data bits, least significant first (7 bits when `cfg_len7`=1, otherwise 8);
  - the extra bit, present when `cfg_xbit` is 1 (parity) or 2 (multiprocessor flag); values 0 and 3 mean no extra bit;
  - stop bits of 1, two when `cfg_stop2`=1, otherwise one.
- R3: The parity bit makes the count of ones over the data bits and the parity bit even when `cfg_par_odd`=0 and odd when it is 1.
- R4: In multiprocessor mode, the extra bit sent is `tx_mpb` as captured with the byte, and the extra bit received is presented on `rx_mpb`.
- R5: A byte that is waiting when the last stop bit ends starts its start bit at once. With the internal tick, consecutive start edges of 8-bit, one-stop characters are exactly 10 x 16 x BAUD_DIV clocks apart.
- R6: A low pulse on `rxd` that has ended before the middle of the start bit (8 ticks) produces no character and no flag.
- R7: A received 7-bit character is placed in `rx_data[6:0]`, and `rx_data[7]` reads 0.
- R8: `sts_fer` is set when the first stop bit samples 0. The character is still delivered.
- R9: `sts_per` is set when a received parity bit does not match the configured even/odd rule.
- R10: `sts_brk` is set, together with `sts_fer`, when a character has a framing error and all its data bits and its extra bit are 0.
- R11: A character that completes while `rx_valid` is 1 and `rx_ready` is 0 is discarded and sets `sts_ore`. The held byte is unchanged, and `sts_ore` stays set until `sts_clr`.
- R12: With `cfg_ext_clk`=1, each rising edge of `ext_clk16` is one oversample tick and the internal divider has no effect, so one bit lasts 16 external periods.
- R13: With the internal source, `bclk_out` is a square wave whose period is 16 x BAUD_DIV clocks. With the external source it is held at 0.
- R14: `rx_valid` and `rx_data` stay unchanged while `rx_ready` is 0. `rx_valid` drops in the cycle after a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_xbit | input | 2 | Extra bit: 0 none, 1 parity, 2 multiprocessor flag, 3 none |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits, 0: one |
| cfg_ext_clk | input | 1 | 1: tick from `ext_clk16`, 0: internal divider |
| ext_clk16 | input | 1 | External clock at 16 times the bit rate |
| bclk_out | output | 1 | Bit-rate clock output (internal source only) |
| tx_data | input | 8 | Byte to send |
| tx_mpb | input | 1 | Multiprocessor flag value to send with the byte |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter can take a byte |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Received multiprocessor flag |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Consumer takes the received byte |
| sts_clr | input | 1 | Clears all four status flags |
| sts_fer | output | 1 | Framing error flag (sticky) |
| sts_per | output | 1 | Parity error flag (sticky) |
| sts_ore | output | 1 | Overrun flag (sticky) |
| sts_brk | output | 1 | Break flag (sticky) |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is completion of a received character and the stream handshake. The bench leaves `rx_ready` low so that a second character completes on top of an unread one. It then judges that the first byte survives and that the overrun flag stays set past the pop, until the clear.

The second pair is the end of the last stop bit and the acceptance of the next transmit byte. The bench holds `tx_valid` high across three characters of all ones and counts clocks between start edges. Any lost cycle shows up as a gap longer than ten bit times.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

  localparam int OVS = 16;

  typedef enum logic [1:0] {
    XB_NONE   = 2'd0,
    XB_PARITY = 2'd1,
    XB_MPFLAG = 2'd2,
    XB_NONE2  = 2'd3
  } xbit_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_XBIT,
    FS_STOP
  } fsm_e;

  function automatic logic par_calc(input logic [7:0] d, input logic len7, input logic odd);
    logic [7:0] m;
    m = len7 ? {1'b0, d[6:0]} : d;
    return (^m) ^ odd;
  endfunction

  function automatic logic has_xbit(input logic [1:0] mode);
    return (mode == XB_PARITY) || (mode == XB_MPFLAG);
  endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int BAUD_DIV = 4,
  parameter int OVS      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic ext_clk16,
  output logic tick16,
  output logic bclk_out
);
  localparam int DW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int OW = $clog2(OVS);

  logic [DW-1:0] dcnt;
  logic [2:0]    esync;
  logic [OW-1:0] ocnt;
  logic          int_tick;
  logic          ext_tick;

  assign int_tick = (dcnt == DW'(BAUD_DIV - 1));
  assign ext_tick = esync[1] & ~esync[2];
  assign tick16   = use_ext ? ext_tick : int_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt     <= '0;
      esync    <= '0;
      ocnt     <= '0;
      bclk_out <= 1'b0;
    end else begin
      dcnt     <= int_tick ? '0 : dcnt + 1'b1;
      esync    <= {esync[1:0], ext_clk16};
      if (tick16) ocnt <= ocnt + 1'b1;
      bclk_out <= !use_ext && (ocnt < OW'(OVS / 2));
    end
  end

  assert_bclk_low_ext_R13: assert property (@(posedge clk) disable iff (!rst_n)
    use_ext |=> !bclk_out);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_mp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       len7,
  input  logic [1:0] xmode,
  input  logic       par_odd,
  input  logic       stop2,
  input  logic [7:0] tx_data,
  input  logic       tx_mpb,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd
);
  localparam int CW = $clog2(OVS);

  fsm_e          state;
  logic [7:0]    sh;
  logic          xb;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic          stop_idx;
  logic          bit_end;
  logic          accept;

  assign bit_end  = tick16 && (tcnt == CW'(OVS - 1));
  assign tx_ready = (state == FS_IDLE) ||
                    (state == FS_STOP && bit_end && (stop_idx == stop2));
  assign accept   = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FS_IDLE;
      sh       <= '0;
      xb       <= 1'b0;
      tcnt     <= '0;
      bidx     <= '0;
      stop_idx <= 1'b0;
      txd      <= 1'b1;
    end else if (accept) begin
      sh    <= tx_data;
      xb    <= (xmode == XB_PARITY) ? par_calc(tx_data, len7, par_odd) : tx_mpb;
      state <= FS_START;
      tcnt  <= '0;
      txd   <= 1'b0;
    end else begin
      if (tick16 && state != FS_IDLE) tcnt <= tcnt + 1'b1;
      case (state)
        FS_IDLE: txd <= 1'b1;
        FS_START: if (bit_end) begin
          state <= FS_DATA;
          bidx  <= '0;
          txd   <= sh[0];
          sh    <= sh >> 1;
        end
        FS_DATA: if (bit_end) begin
          if (bidx == (len7 ? 3'd6 : 3'd7)) begin
            if (has_xbit(xmode)) begin
              state <= FS_XBIT;
              txd   <= xb;
            end else begin
              state    <= FS_STOP;
              stop_idx <= 1'b0;
              txd      <= 1'b1;
            end
          end else begin
            bidx <= bidx + 1'b1;
            txd  <= sh[0];
            sh   <= sh >> 1;
          end
        end
        FS_XBIT: if (bit_end) begin
          state    <= FS_STOP;
          stop_idx <= 1'b0;
          txd      <= 1'b1;
        end
        FS_STOP: if (bit_end) begin
          if (stop_idx == stop2) state <= FS_IDLE;
          else                   stop_idx <= 1'b1;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assert_txd_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == FS_IDLE) |-> txd);

  assert_tx_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != FS_IDLE && !tick16 && !accept) |=> $stable(tcnt) && $stable(txd));

endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_mp_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       len7,
  input  logic [1:0] xmode,
  input  logic       par_odd,
  input  logic       rx_ready,
  input  logic       sts_clr,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       rx_valid,
  output logic       sts_fer,
  output logic       sts_per,
  output logic       sts_ore,
  output logic       sts_brk
);
  localparam int CW = $clog2(OVS);

  logic [1:0]    rsync;
  logic          rs;
  fsm_e          state;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          xbit;
  logic          samp;
  logic          done;
  logic [7:0]    dfin;
  logic          set_fer, set_per, set_brk, set_ore;
  logic          blocked;

  assign rs      = rsync[1];
  assign samp    = tick16 && (tcnt == CW'(OVS - 1));
  assign done    = (state == FS_STOP) && samp;
  assign dfin    = len7 ? {1'b0, sh[7:1]} : sh;
  assign blocked = rx_valid && !rx_ready;
  assign set_fer = done && !rs;
  assign set_per = done && (xmode == XB_PARITY) && (xbit != par_calc(dfin, len7, par_odd));
  assign set_brk = set_fer && (dfin == 8'h00) && (!has_xbit(xmode) || !xbit);
  assign set_ore = done && blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= 2'b11;
      state <= FS_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      sh    <= '0;
      xbit  <= 1'b0;
    end else begin
      rsync <= {rsync[0], rxd};
      case (state)
        FS_IDLE: if (tick16 && !rs) begin
          state <= FS_START;
          tcnt  <= '0;
        end
        FS_START: if (tick16) begin
          if (tcnt == CW'(OVS / 2 - 1)) begin
            tcnt <= '0;
            bidx <= '0;
            state <= rs ? FS_IDLE : FS_DATA;
          end else tcnt <= tcnt + 1'b1;
        end
        FS_DATA: if (tick16) begin
          tcnt <= tcnt + 1'b1;
          if (samp) begin
            sh <= {rs, sh[7:1]};
            if (bidx == (len7 ? 3'd6 : 3'd7))
              state <= has_xbit(xmode) ? FS_XBIT : FS_STOP;
            else bidx <= bidx + 1'b1;
          end
        end
        FS_XBIT: if (tick16) begin
          tcnt <= tcnt + 1'b1;
          if (samp) begin
            xbit  <= rs;
            state <= FS_STOP;
          end
        end
        FS_STOP: if (tick16) begin
          tcnt <= tcnt + 1'b1;
          if (samp) state <= FS_IDLE;
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_mpb   <= 1'b0;
      rx_valid <= 1'b0;
      sts_fer  <= 1'b0;
      sts_per  <= 1'b0;
      sts_ore  <= 1'b0;
      sts_brk  <= 1'b0;
    end else begin
      sts_fer <= (sts_fer && !sts_clr) || set_fer;
      sts_per <= (sts_per && !sts_clr) || set_per;
      sts_ore <= (sts_ore && !sts_clr) || set_ore;
      sts_brk <= (sts_brk && !sts_clr) || set_brk;
      if (done && !blocked) begin
        rx_data  <= dfin;
        rx_mpb   <= (xmode == XB_MPFLAG) && xbit;
        rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end

  assert_rx_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> rx_valid && $stable(rx_data));

  assert_ore_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ore && !sts_clr) |=> sts_ore);

  assert_brk_with_fer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_brk) |-> sts_fer);

  assert_rx7_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len7 && !blocked) |=> (rx_data[7] == 1'b0));

endmodule

// File: rtl/uart_mp_xcvr.sv
module uart_mp_xcvr
  import uart_mp_pkg::*;
#(
  parameter int BAUD_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_len7,
  input  logic [1:0] cfg_xbit,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_ext_clk,
  input  logic       ext_clk16,
  output logic       bclk_out,
  input  logic [7:0] tx_data,
  input  logic       tx_mpb,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       rx_valid,
  input  logic       rx_ready,
  input  logic       sts_clr,
  output logic       sts_fer,
  output logic       sts_per,
  output logic       sts_ore,
  output logic       sts_brk,
  output logic       txd,
  input  logic       rxd
);
  logic tick16;

  uart_tick_gen #(.BAUD_DIV(BAUD_DIV), .OVS(OVS)) u_tick (
    .clk(clk), .rst_n(rst_n), .use_ext(cfg_ext_clk), .ext_clk16(ext_clk16),
    .tick16(tick16), .bclk_out(bclk_out)
  );

  uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .len7(cfg_len7), .xmode(cfg_xbit),
    .par_odd(cfg_par_odd), .stop2(cfg_stop2), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
  );

  uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .len7(cfg_len7),
    .xmode(cfg_xbit), .par_odd(cfg_par_odd), .rx_ready(rx_ready), .sts_clr(sts_clr),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_valid(rx_valid), .sts_fer(sts_fer),
    .sts_per(sts_per), .sts_ore(sts_ore), .sts_brk(sts_brk)
  );

endmodule

// File: tb/uart_mp_xcvr_tb_top.sv
`timescale 1ns/1ps
module uart_mp_xcvr_tb_top;
  localparam int BAUD_DIV = 4;
  localparam int BIT      = 16 * BAUD_DIV;
  localparam int EXT_HALF = 3;
  localparam int BITX     = 16 * 2 * EXT_HALF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_len7 = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_ext_clk = 1'b0;
  logic [1:0] cfg_xbit = 2'd0;
  logic ext_clk16 = 1'b0;
  logic bclk_out;
  logic [7:0] tx_data = 8'h00;
  logic tx_mpb = 1'b0, tx_valid = 1'b0, tx_ready;
  logic [7:0] rx_data;
  logic rx_mpb, rx_valid;
  logic rx_ready = 1'b0, sts_clr = 1'b0;
  logic sts_fer, sts_per, sts_ore, sts_brk;
  logic txd, rxd;
  logic lb = 1'b1;
  logic drv = 1'b1;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  assign rxd = lb ? txd : drv;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (EXT_HALF) @(negedge clk);
    ext_clk16 = ~ext_clk16;
  end

  uart_mp_xcvr #(.BAUD_DIV(BAUD_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len7(cfg_len7), .cfg_xbit(cfg_xbit),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .cfg_ext_clk(cfg_ext_clk),
    .ext_clk16(ext_clk16), .bclk_out(bclk_out), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .sts_clr(sts_clr), .sts_fer(sts_fer),
    .sts_per(sts_per), .sts_ore(sts_ore), .sts_brk(sts_brk), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] frame_bits(input logic [7:0] d, input int nd,
                                             input int hasx, input logic xv, input int ns);
    logic [15:0] v;
    v = '1;
    v[0] = 1'b0;
    for (int i = 0; i < nd; i++) v[1+i] = d[i];
    if (hasx != 0) v[1+nd] = xv;
    for (int i = 0; i < ns; i++) v[1+nd+hasx+i] = 1'b1;
    return v;
  endfunction

  task automatic grab_frame(input int n, input int bitc, output logic [15:0] got);
    got = '1;
    @(negedge clk);
    while (txd) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      repeat ((i == 0) ? bitc / 2 : bitc) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic push(input logic [7:0] d, input logic mpb);
    @(negedge clk);
    tx_data = d; tx_mpb = mpb; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp, input logic expmpb);
    @(negedge clk);
    chk(req, "rx_valid", rx_valid, 1);
    chk(req, "rx_data", rx_data, exp);
    chk("R4", "rx_mpb", rx_mpb, expmpb);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk("R14", "rx_valid after pop", rx_valid, 0);
  endtask

  task automatic drive_frame(input logic [7:0] d, input int nd, input int hasx, input logic xv,
                             input logic stopv, input int stop_clks);
    @(negedge clk);
    drv = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < nd; i++) begin drv = d[i]; repeat (BIT) @(negedge clk); end
    if (hasx != 0) begin drv = xv; repeat (BIT) @(negedge clk); end
    drv = stopv; repeat (stop_clks) @(negedge clk);
    drv = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
  endtask

  task automatic loop_frame(input string req, input logic [7:0] d, input logic mpb, input int nd,
                            input int hasx, input logic xv, input int ns, input int bitc,
                            input logic [7:0] rexp, input logic rmpb);
    logic [15:0] got, exp;
    int n;
    n = 1 + nd + hasx + ns;
    exp = frame_bits(d, nd, hasx, xv, ns);
    fork
      push(d, mpb);
      grab_frame(n, bitc, got);
    join
    chk(req, "serial frame", got, exp);
    repeat (bitc) @(negedge clk);
    pop_check(req, rexp, rmpb);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "txd idle", txd, 1);
    chk("R1", "tx_ready", tx_ready, 1);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "flags", {sts_fer, sts_per, sts_ore, sts_brk}, 0);
  endtask

  task automatic t_basic8();
    cfg_len7 = 0; cfg_xbit = 2'd0; cfg_stop2 = 0; lb = 1;
    fork
      loop_frame("R2", 8'hA5, 1'b0, 8, 0, 1'b0, 1, BIT, 8'hA5, 1'b0);
      begin
        repeat (BIT * 12) @(negedge clk);
      end
    join
  endtask

  task automatic t_hold();
    logic [15:0] got;
    cfg_len7 = 0; cfg_xbit = 2'd0; cfg_stop2 = 0; lb = 1;
    fork push(8'h3E, 1'b0); grab_frame(10, BIT, got); join
    repeat (BIT * 3) @(negedge clk);
    chk("R14", "held valid", rx_valid, 1);
    chk("R14", "held data", rx_data, 8'h3E);
    pop_check("R14", 8'h3E, 1'b0);
  endtask

  task automatic t_parity();
    cfg_len7 = 0; cfg_xbit = 2'd1; cfg_stop2 = 1; cfg_par_odd = 0; lb = 1;
    loop_frame("R3", 8'h07, 1'b0, 8, 1, 1'b1, 2, BIT, 8'h07, 1'b0);
    cfg_par_odd = 1;
    loop_frame("R3", 8'h07, 1'b0, 8, 1, 1'b0, 2, BIT, 8'h07, 1'b0);
    chk("R3", "no parity error", sts_per, 0);
    cfg_par_odd = 0; cfg_stop2 = 0;
  endtask

  task automatic t_mp();
    cfg_len7 = 0; cfg_xbit = 2'd2; cfg_stop2 = 0; lb = 1;
    loop_frame("R4", 8'h3C, 1'b1, 8, 1, 1'b1, 1, BIT, 8'h3C, 1'b1);
    loop_frame("R4", 8'hC1, 1'b0, 8, 1, 1'b0, 1, BIT, 8'hC1, 1'b0);
    cfg_xbit = 2'd0;
  endtask

  task automatic t_len7();
    cfg_len7 = 1; cfg_xbit = 2'd0; cfg_stop2 = 0; lb = 1;
    loop_frame("R7", 8'hFF, 1'b0, 7, 0, 1'b0, 1, BIT, 8'h7F, 1'b0);
    cfg_len7 = 0;
  endtask

  task automatic t_b2b();
    int t[3];
    cfg_len7 = 0; cfg_xbit = 2'd0; cfg_stop2 = 0; lb = 0; drv = 1;
    fork
      begin push(8'hFF, 0); push(8'hFF, 0); push(8'hFF, 0); end
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          while (txd) @(negedge clk);
          t[k] = cyc;
          while (!txd) @(negedge clk);
        end
      end
    join
    chk("R5", "start-to-start gap", t[2] - t[1], 10 * BIT);
    chk("R5", "first gap within a tick", ((t[1] - t[0]) <= 10 * BIT) && ((t[1] - t[0]) >= 10 * BIT - BAUD_DIV), 1);
    repeat (BIT * 12) @(negedge clk);
    chk("R5", "no rx activity", rx_valid, 0);
  endtask

  task automatic t_glitch();
    lb = 0; drv = 1;
    @(negedge clk); drv = 0;
    repeat (BIT / 4) @(negedge clk); drv = 1;
    repeat (BIT * 12) @(negedge clk);
    chk("R6", "glitch gives no char", rx_valid, 0);
    chk("R6", "glitch gives no flag", {sts_fer, sts_per, sts_ore, sts_brk}, 0);
    drive_frame(8'h5A, 8, 0, 1'b0, 1'b1, BIT);
    pop_check("R6", 8'h5A, 1'b0);
  endtask

  task automatic t_framing();
    lb = 0; cfg_xbit = 2'd0;
    drive_frame(8'h81, 8, 0, 1'b0, 1'b0, BIT * 5 / 8);
    repeat (BIT) @(negedge clk);
    chk("R8", "framing flag", sts_fer, 1);
    chk("R10", "no break for nonzero data", sts_brk, 0);
    pop_check("R8", 8'h81, 1'b0);
    clear_flags();
    chk("R8", "flag cleared", sts_fer, 0);
  endtask

  task automatic t_break();
    lb = 0; cfg_xbit = 2'd0;
    drive_frame(8'h00, 8, 0, 1'b0, 1'b0, BIT * 5 / 8);
    repeat (BIT) @(negedge clk);
    chk("R10", "break flag", sts_brk, 1);
    chk("R10", "framing with break", sts_fer, 1);
    pop_check("R10", 8'h00, 1'b0);
    clear_flags();
    chk("R10", "break cleared", sts_brk, 0);
  endtask

  task automatic t_parerr();
    lb = 0; cfg_xbit = 2'd1; cfg_par_odd = 0;
    drive_frame(8'h01, 8, 1, 1'b0, 1'b1, BIT);
    chk("R9", "parity error flag", sts_per, 1);
    chk("R8", "no framing error", sts_fer, 0);
    pop_check("R9", 8'h01, 1'b0);
    clear_flags();
    cfg_xbit = 2'd0;
  endtask

  task automatic t_overrun();
    lb = 0; cfg_xbit = 2'd0;
    drive_frame(8'h11, 8, 0, 1'b0, 1'b1, BIT);
    chk("R11", "no overrun yet", sts_ore, 0);
    drive_frame(8'h22, 8, 0, 1'b0, 1'b1, BIT);
    chk("R11", "overrun flag", sts_ore, 1);
    pop_check("R11", 8'h11, 1'b0);
    repeat (BIT) @(negedge clk);
    chk("R11", "overrun sticky after pop", sts_ore, 1);
    chk("R11", "second char discarded", rx_valid, 0);
    clear_flags();
    chk("R11", "overrun cleared", sts_ore, 0);
  endtask

  task automatic t_ext();
    int hi;
    cfg_ext_clk = 1; cfg_xbit = 2'd0; lb = 1;
    hi = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < BIT * 4; i++) begin @(negedge clk); if (bclk_out) hi++; end
    chk("R13", "bclk_out low on external clock", hi, 0);
    loop_frame("R12", 8'hC3, 1'b0, 8, 0, 1'b0, 1, BITX, 8'hC3, 1'b0);
    cfg_ext_clk = 0;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic t_bclk();
    int r0, r1;
    @(negedge clk);
    while (bclk_out) @(negedge clk);
    while (!bclk_out) @(negedge clk);
    r0 = cyc;
    while (bclk_out) @(negedge clk);
    while (!bclk_out) @(negedge clk);
    r1 = cyc;
    chk("R13", "bclk_out period", r1 - r0, BIT);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic8();
    t_hold();
    t_parity();
    t_mp();
    t_len7();
    t_b2b();
    t_glitch();
    t_framing();
    t_break();
    t_parerr();
    t_overrun();
    t_bclk();
    t_ext();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule